// File: doc/BRIEF.md
# Reversible Thermometer-to-Binary Encoder

This block sits behind the comparator bank of a flash converter. It turns the bank's thermometer word into a binary level code. A comparator output reads 1 while the analog input is still below that comparator's reference and drops to 0 once the input has passed it. An idle input therefore shows all ones, and full scale shows all zeros.

The encoder is a netlist of reversible gates only: the two-line controlled-NOT (cost 1) and the three-line doubly controlled NOT (cost 5). Lines that need a known starting value are tied to constant 0 or 1. For every comparator position k, a boundary flag is formed, true when comparator k is low and the comparator above it is high (or k is the topmost). Each flag is then folded with XOR into the output bits that are set in the binary value of k. Every line that ends neither as an output nor as a gate input leaves through a garbage port. The block also drives its own gate count, garbage-line count and quantum cost as constant outputs, derived from the parameter.

Top module: `thermo_rev_encoder`

## Requirements
- R1: `therm_i` bit k-1 carries comparator k, for k = 1..N with N = 2^ADC_BITS - 1. For a legal word at level L (bits 0..L-1 zero, all higher bits one), `code_o` equals L.
- R2: An all-ones input word (lowest range) gives `code_o` = 0.
- R3: An all-zeros input word (full scale) gives `code_o` = N, which is all ones in binary.
- R4: For any known input, including bubbled words, `code_o` is the XOR of every k whose boundary flag is set. The flag is set when bit k-1 is 0 and either k = N or bit k is 1. `code_o` never carries X for a known input.
- R5: `garbage_o[N-1:0]` equals `therm_i`, because the comparator lines pass through the gate controls unchanged.
- R6: `garbage_o[N+k-1]` is the boundary flag of position k. For a legal word it is one-hot at bit N+L-1 when L ≥ 1, and all zero when L = 0.
- R7: `gate_cnt_o` = 2N - 1 + P, where P = ADC_BITS·2^(ADC_BITS-1). This is 25 at the default.
- R8: `qcost_o` = 6N - 5 + P, which is 49 at the default.
- R9: `garbage_cnt_o` = 2N, which is 14 at the default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| therm_i | input | 2^ADC_BITS-1 | Comparator outputs, bit k-1 is comparator k, 0 means the input has passed that reference |
| code_o | output | ADC_BITS | Binary level code |
| garbage_o | output | 2·(2^ADC_BITS-1) | Low half: comparator lines after their last gate; high half: boundary flag lines after fan-out |
| gate_cnt_o | output | CNT_W | Number of reversible gates in the netlist |
| garbage_cnt_o | output | CNT_W | Number of garbage lines |
| qcost_o | output | CNT_W | Total quantum cost |

## Verification
The bench builds two copies of the encoder, one with ADC_BITS = 3 (seven comparators) and one with ADC_BITS = 2 (three comparators). Both are swept over every legal level and over every possible input word, bubbled ones included. The smaller copy shows that the boundary-flag generation and the per-bit fan-out follow the parameter rather than a fixed seven-input layout. Its totals (9 gates, 6 garbage lines, cost 17) check the count formulas at a second point.

// File: rtl/thermo_rev_pkg.sv
// Shared constants and helpers for the reversible thermometer encoder.
// Assumes gate costs follow the usual two-line primitive accounting.
package thermo_rev_pkg;

    localparam int CNOT_COST    = 1;
    localparam int TOFFOLI_COST = 5;

    // Number of fan-out gates: total count of set bits over the values 1..n.
    function automatic int fanout_terms(input int n, input int bits);
        int s;
        s = 0;
        for (int k = 1; k <= n; k++) begin
            for (int b = 0; b < bits; b++) begin
                if (((k >> b) & 1) == 1) s = s + 1;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/rev_cnot.sv
// Two-line reversible controlled-NOT: the control passes through and
// the target is XORed with the control. Purely combinational.
module rev_cnot (
    input  logic a_i,
    input  logic b_i,
    output logic p_o,
    output logic q_o
);

    // Control line pass-through.
    assign p_o = a_i;
    // Target line toggled by the control.
    assign q_o = a_i ^ b_i;

endmodule

// File: rtl/rev_toffoli.sv
// Three-line reversible doubly controlled NOT: both controls pass
// through and the target is XORed with their AND. Purely combinational.
module rev_toffoli (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic p_o,
    output logic q_o,
    output logic r_o
);

    // First control pass-through.
    assign p_o = a_i;
    // Second control pass-through.
    assign q_o = b_i;
    // Target toggled by the product of the controls.
    assign r_o = (a_i & b_i) ^ c_i;

endmodule

// File: rtl/rev_boundary_cell.sv
// Boundary detector for one comparator position k below the top.
// It copies comparator k+1 onto a zero ancilla, then a Toffoli gate
// controlled by comparator k and comparator k+1 turns that copy into
// flag = C(k+1) & ~C(k). Assumes the lo_i line still carries the raw
// comparator k value.
module rev_boundary_cell (
    input  logic lo_i,
    input  logic hi_i,
    output logic lo_o,
    output logic hi_o,
    output logic flag_o
);

    logic hi_mid;
    logic hi_copy;

    // Copy the upper comparator onto a constant-zero ancilla.
    rev_cnot copy_g (
        .a_i (hi_i),
        .b_i (1'b0),
        .p_o (hi_mid),
        .q_o (hi_copy)
    );

    // Clear the copy wherever the lower comparator is still high.
    rev_toffoli mask_g (
        .a_i (lo_i),
        .b_i (hi_mid),
        .c_i (hi_copy),
        .p_o (lo_o),
        .q_o (hi_o),
        .r_o (flag_o)
    );

endmodule

// File: rtl/thermo_rev_encoder.sv
// Reversible thermometer-to-binary encoder for a flash converter of
// ADC_BITS bits. One boundary flag is formed per comparator position,
// and each flag is XOR-folded into the output bits set in its index.
// Assumes inverted thermometer input (0 = reference passed). Garbage
// lines are exported so that the full netlist stays observable.
module thermo_rev_encoder #(
    parameter  int ADC_BITS = 3,
    parameter  int CNT_W    = 8,
    localparam int N_CMP    = (1 << ADC_BITS) - 1,
    localparam int N_GARB   = 2 * N_CMP
) (
    input  logic [N_CMP-1:0]    therm_i,
    output logic [ADC_BITS-1:0] code_o,
    output logic [N_GARB-1:0]   garbage_o,
    output logic [CNT_W-1:0]    gate_cnt_o,
    output logic [CNT_W-1:0]    garbage_cnt_o,
    output logic [CNT_W-1:0]    qcost_o
);

    import thermo_rev_pkg::*;

    localparam int FAN_GATES = fanout_terms(N_CMP, ADC_BITS);
    localparam int GATES     = 2 * (N_CMP - 1) + 1 + FAN_GATES;
    localparam int QCOST     = (CNOT_COST + TOFFOLI_COST) * (N_CMP - 1)
                               + CNOT_COST + CNOT_COST * FAN_GATES;

    logic [N_CMP:1]    cline;
    logic [N_CMP:1]    flag;
    logic [ADC_BITS:0] eline [N_CMP:1];
    logic [N_CMP:0]    qacc  [ADC_BITS];

    // Comparator 1 line enters the first boundary cell unchanged.
    assign cline[1] = therm_i[0];

    // Boundary cells for every position below the top comparator.
    for (genvar k = 1; k < N_CMP; k++) begin : g_cell
        rev_boundary_cell cell_i (
            .lo_i   (cline[k]),
            .hi_i   (therm_i[k]),
            .lo_o   (garbage_o[k-1]),
            .hi_o   (cline[k+1]),
            .flag_o (flag[k])
        );
    end

    // Top position: flag is the complement, formed on a constant-one line.
    rev_cnot top_g (
        .a_i (cline[N_CMP]),
        .b_i (1'b1),
        .p_o (garbage_o[N_CMP-1]),
        .q_o (flag[N_CMP])
    );

    // Output accumulators start from constant zero lines.
    for (genvar j = 0; j < ADC_BITS; j++) begin : g_out
        assign qacc[j][0] = 1'b0;
        assign code_o[j]  = qacc[j][N_CMP];
    end

    // Fan each flag out onto the output bits set in its own index.
    for (genvar k = 1; k <= N_CMP; k++) begin : g_fan
        assign eline[k][0] = flag[k];
        for (genvar j = 0; j < ADC_BITS; j++) begin : g_bit
            if (((k >> j) & 1) == 1) begin : g_tap
                rev_cnot tap_i (
                    .a_i (eline[k][j]),
                    .b_i (qacc[j][k-1]),
                    .p_o (eline[k][j+1]),
                    .q_o (qacc[j][k])
                );
            end else begin : g_skip
                assign eline[k][j+1] = eline[k][j];
                assign qacc[j][k]    = qacc[j][k-1];
            end
        end
        assign garbage_o[N_CMP+k-1] = eline[k][ADC_BITS];
    end

    // Netlist totals derived from the parameter.
    assign gate_cnt_o    = CNT_W'(GATES);
    assign garbage_cnt_o = CNT_W'(N_GARB);
    assign qcost_o       = CNT_W'(QCOST);

endmodule

// File: rtl/thermo_rev_encoder_chk.sv
// Property checker for the encoder, attached by bind. Evaluates only
// when the input word is fully known.
module thermo_rev_encoder_chk #(
    parameter  int ADC_BITS = 3,
    localparam int N_CMP    = (1 << ADC_BITS) - 1
) (
    input logic [N_CMP-1:0]    therm_i,
    input logic [ADC_BITS-1:0] code_o,
    input logic [2*N_CMP-1:0]  garbage_o
);

    logic [N_CMP-1:0] zeros;
    logic             legal;

    // Derive the passed-reference mask and the legality of the word.
    always_comb begin
        zeros = ~therm_i;
        legal = ((zeros & (zeros + 1'b1)) == '0);
    end

    // Port relations checked whenever the input is known.
    always_comb begin
        if (!$isunknown(therm_i)) begin
            // R1
            level_match_chk: assert (!legal || code_o == ADC_BITS'($countones(zeros)))
                else $error("level mismatch");
            // R4
            code_known_chk: assert (!$isunknown(code_o))
                else $error("unknown code");
            // R5
            line_pass_chk: assert (garbage_o[N_CMP-1:0] == therm_i)
                else $error("comparator line altered");
            // R6
            flag_onehot_chk: assert (!legal || $onehot0(garbage_o[2*N_CMP-1:N_CMP]))
                else $error("boundary flags not one-hot");
            // R6
            top_flag_chk: assert (garbage_o[2*N_CMP-1] == ~therm_i[N_CMP-1])
                else $error("top flag wrong");
        end
    end

endmodule

bind thermo_rev_encoder thermo_rev_encoder_chk #(.ADC_BITS(ADC_BITS)) chk_i (
    .therm_i   (therm_i),
    .code_o    (code_o),
    .garbage_o (garbage_o)
);

// File: tb/thermo_rev_encoder_tb_top.sv
module thermo_rev_encoder_tb_top;

    logic       clk = 1'b0;
    logic [6:0] therm3 = 7'h7F;
    logic [2:0] therm2 = 3'h7;
    logic [2:0]  code3;
    logic [13:0] garb3;
    logic [7:0]  gc3, gb3, qc3;
    logic [1:0]  code2;
    logic [5:0]  garb2;
    logic [7:0]  gc2, gb2, qc2;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    thermo_rev_encoder #(.ADC_BITS(3)) dut_i (
        .therm_i(therm3), .code_o(code3), .garbage_o(garb3),
        .gate_cnt_o(gc3), .garbage_cnt_o(gb3), .qcost_o(qc3));

    thermo_rev_encoder #(.ADC_BITS(2)) dut_small_i (
        .therm_i(therm2), .code_o(code2), .garbage_o(garb2),
        .gate_cnt_o(gc2), .garbage_cnt_o(gb2), .qcost_o(qc2));

    function automatic logic [6:0] ref_flags(int n, logic [6:0] t);
        logic [6:0] f = '0;
        for (int k = 1; k <= n; k++) begin
            if (t[k-1] == 1'b0 && (k == n || t[k] == 1'b1)) f[k-1] = 1'b1;
        end
        return f;
    endfunction

    function automatic int ref_code(int n, logic [6:0] t);
        int acc = 0;
        logic [6:0] f = ref_flags(n, t);
        for (int k = 1; k <= n; k++) if (f[k-1]) acc = acc ^ k;
        return acc;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(logic [6:0] t3, logic [2:0] t2);
        @(negedge clk);
        therm3 = t3;
        therm2 = t2;
        #1;
    endtask

    // R2: idle (all ones) word on both copies.
    task automatic t_idle;
        apply(7'h7F, 3'h7);
        chk("R2 idle 3b", 32'(code3), 0);
        chk("R2 idle 2b", 32'(code2), 0);
        chk("R6 idle flags zero", 32'(garb3[13:7]), 0);
    endtask

    // R3: full-scale (all zeros) word.
    task automatic t_full;
        apply(7'h00, 3'h0);
        chk("R3 full 3b", 32'(code3), 7);
        chk("R3 full 2b", 32'(code2), 3);
    endtask

    // R1, R5, R6: every legal level.
    task automatic t_ladder;
        for (int l = 0; l <= 7; l++) begin
            logic [6:0] t = 7'((7'h7F) << l);
            logic [2:0] s = 3'((3'h7) << (l > 3 ? 3 : l));
            apply(t, s);
            chk("R1 level 3b", 32'(code3), 32'(l));
            chk("R5 pass lines", 32'(garb3[6:0]), 32'(t));
            chk("R6 flag onehot", 32'(garb3[13:7]), (l == 0) ? 0 : (32'd1 << (l - 1)));
            if (l <= 3) begin
                chk("R1 level 2b", 32'(code2), 32'(l));
                chk("R6 flag onehot 2b", 32'(garb2[5:3]), (l == 0) ? 0 : (32'd1 << (l - 1)));
            end
        end
    endtask

    // R4, R5, R6: every input word, bubbled ones included.
    task automatic t_every_word;
        for (int v = 0; v < 128; v++) begin
            logic [6:0] t = 7'(v);
            logic [2:0] s = 3'(v);
            apply(t, s);
            chk("R4 xor code 3b", 32'(code3), 32'(ref_code(7, t)));
            chk("R4 no X", 32'($isunknown(code3)), 0);
            chk("R6 flags 3b", 32'(garb3[13:7]), 32'(ref_flags(7, t)));
            chk("R5 pass 2b", 32'(garb2[2:0]), 32'(s));
            chk("R4 xor code 2b", 32'(code2), 32'(ref_code(3, {4'b0, s})));
        end
    endtask

    // R7, R8, R9: netlist totals.
    task automatic t_totals;
        chk("R7 gates 3b", 32'(gc3), 25);
        chk("R8 cost 3b", 32'(qc3), 49);
        chk("R9 garbage 3b", 32'(gb3), 14);
        chk("R7 gates 2b", 32'(gc2), 9);
        chk("R8 cost 2b", 32'(qc2), 17);
        chk("R9 garbage 2b", 32'(gb2), 6);
    endtask

    initial begin
        t_idle;
        t_full;
        t_ladder;
        t_every_word;
        t_totals;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule